// File: doc/BRIEF.md
# Parallel Eight-Lane SPI DAC Writer

This block keeps eight signed 16-bit set-points in a small register bank. Software reaches the bank through a simple address, data and write-strobe port that stands in for an AXI4-Lite slave. Writing a 1 into the trigger bit, when that bit was 0, makes the block copy all eight set-points into shift registers. It then sends them to eight DACs in one frame. The DACs share one serial clock and one active-low chip-select, and each DAC has its own serial data lane. All eight words therefore arrive at the same time.

The serial clock runs at half the core clock and cannot be changed. The transfer is sequenced by a four-state machine:

- `ST_IDLE`: chip-select high, clock low, lanes low.
- `ST_SETUP`: one core cycle. Chip-select is low, the clock is still low and every lane shows its MSB.
- `ST_SHIFT`: alternates a high clock cycle and a low clock cycle, 16 times.
- `ST_HOLD`: one core cycle with the clock low and chip-select still low.

The transitions are:

- `IDLE→SETUP` on an accepted trigger edge.
- `SETUP→SHIFT` unconditionally.
- `SHIFT→SHIFT` while bits remain.
- `SHIFT→HOLD` after the high phase of bit 16.
- `HOLD→IDLE` unconditionally.

A DAC keeps its last latched word, so the block must never produce a chip-select pulse that software did not request.

Top module: `par_dac_writer`

## Requirements
- R1: After reset, `dac_cs_n` is 1, `dac_sclk` is 0, every lane of `dac_sdo` is 0, and all channel registers and the trigger bit read as 0. Whenever `dac_cs_n` is high, all lanes are 0.
- R2: Channel n (n = 0..7) sits at byte address 0x104 + 4·n. A write stores `reg_wdata[15:0]`. A read returns the last stored value, sign-extended to 32 bits, at any time, including during a frame.
- R3: The trigger bit is bit 0 at address 0x100. A frame starts only when a write changes this bit from 0 to 1. Writing 1 while the bit is already 1 starts no frame.
- R4: A read at 0x100 returns the trigger bit in bit 0 and a busy flag in bit 1. Busy is 1 from the cycle after the accepted trigger write until chip-select returns high.
- R5: Each frame carries exactly 16 bits on every lane, MSB first. Lane n carries channel n, and all lanes are clocked by the same clock edges.
- R6: During a frame, `dac_sclk` is high for one core cycle and low for one core cycle, so consecutive rising edges are exactly 2 core cycles apart. `dac_sclk` is never high while `dac_cs_n` is high.
- R7: Within a frame, a lane changes only in a cycle where `dac_sclk` falls. Its value is therefore the same in the cycle before and the cycle of every rising edge.
- R8: Every accepted trigger gives exactly one chip-select pulse of 33 core cycles. The pulse has one low-clock cycle before the first rising edge and one after the 16th. No other chip-select pulse occurs.
- R9: The frame carries the channel values as they were in the cycle of the trigger write. Channel writes during a frame change only later frames.
- R10: A 0-to-1 trigger write made while busy is ignored. It starts no frame, now or later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 12 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| dac_sclk | output | 1 | Shared serial clock, half the core rate |
| dac_cs_n | output | 1 | Shared active-low chip-select |
| dac_sdo | output | 8 | One serial data lane per DAC |

## Verification
The assertions assume that `reg_wr` is a single-cycle strobe and that `reg_addr` and `reg_wdata` are stable while it is high. They also assume that reset is held for at least one clock edge before the first write. The stimulus meets these conditions by driving every register access on the falling clock edge, for exactly one cycle, from a single task.

The bench then exercises the cases where the trigger and the data interact with a frame in flight:
- A trigger bit that is already set.
- A retrigger while busy.
- A channel rewrite while busy.
- Extreme signed codes such as 0x8000, 0x7FFE and 0xFFFF.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_SHIFT = 2'd2,
        ST_HOLD  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/pdw_regbank.sv
module pdw_regbank #(
    parameter int NUM_CH    = 8,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 12,
    parameter int REG_W     = 32,
    parameter int TRIG_OFS  = 'h100,
    parameter int CH_BASE   = 'h104,
    parameter int CH_STRIDE = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [REG_W-1:0]         wdata,
    input  logic                     busy,
    output logic [REG_W-1:0]         rdata,
    output logic [NUM_CH*DATA_W-1:0] ch_flat,
    output logic                     start
);
    localparam logic [ADDR_W-1:0] TRIG_ADDR = ADDR_W'(TRIG_OFS);

    logic [DATA_W-1:0] ch_q [NUM_CH];
    logic              trig_q;
    logic              trig_hit;
    logic              wdata_unused;

    assign wdata_unused = ^wdata[REG_W-1:DATA_W];
    assign trig_hit     = wr && (addr == TRIG_ADDR);
    assign start        = trig_hit && wdata[0] && !trig_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        trig_q <= 1'b0;
        else if (trig_hit) trig_q <= wdata[0];
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CH_BASE + g*CH_STRIDE);
        always_ff @(posedge clk) begin
            if (!rst_n)                        ch_q[g] <= '0;
            else if (wr && (addr == MY_ADDR))  ch_q[g] <= wdata[DATA_W-1:0];
        end
        assign ch_flat[g*DATA_W +: DATA_W] = ch_q[g];
    end

    always_comb begin
        rdata = '0;
        if (addr == TRIG_ADDR) begin
            rdata[0] = trig_q;
            rdata[1] = busy;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(CH_BASE + i*CH_STRIDE))
                rdata = {{(REG_W-DATA_W){ch_q[i][DATA_W-1]}}, ch_q[i]};
        end
    end

    AST_START_SETS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> trig_q); // R3
    AST_TRIG_RISES_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_q) |-> $past(wr)); // R3
endmodule

// File: rtl/pdw_lane.sv
module pdw_lane #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic              clear,
    input  logic [DATA_W-1:0] din,
    output logic              sdo
);
    logic [DATA_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) sh_q <= '0;
        else if (load)       sh_q <= din;
        else if (shift)      sh_q <= {sh_q[DATA_W-2:0], 1'b0};
    end

    assign sdo = sh_q[DATA_W-1];
endmodule

// File: rtl/pdw_seq.sv
module pdw_seq
    import pdw_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic load,
    output logic shift,
    output logic clear,
    output logic sclk,
    output logic cs_n
);
    localparam int             CNT_W   = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W-1);
    localparam int             LOW_W   = $clog2(2*DATA_W+1);
    localparam logic [LOW_W-1:0] LOW_LEN = LOW_W'(2*DATA_W);

    seq_state_e       state_q, state_d;
    logic             phase_q, phase_d;
    logic [CNT_W-1:0] bit_q, bit_d;
    logic [LOW_W-1:0] low_q;
    logic             last_hi;

    assign last_hi = (state_q == ST_SHIFT) && phase_q && (bit_q == LAST_BIT);

    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        bit_d   = bit_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_SETUP;
            ST_SETUP: begin
                state_d = ST_SHIFT;
                phase_d = 1'b1;
                bit_d   = '0;
            end
            ST_SHIFT: begin
                if (!phase_q)     phase_d = 1'b1;
                else if (last_hi) state_d = ST_HOLD;
                else begin
                    phase_d = 1'b0;
                    bit_d   = bit_q + 1'b1;
                end
            end
            ST_HOLD:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= 1'b0;
            bit_q   <= '0;
            low_q   <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            bit_q   <= bit_d;
            if (state_q == ST_IDLE) low_q <= '0;
            else                    low_q <= low_q + 1'b1;
        end
    end

    always_comb begin
        busy  = (state_q != ST_IDLE);
        cs_n  = (state_q == ST_IDLE);
        sclk  = (state_q == ST_SHIFT) && phase_q;
        load  = (state_q == ST_IDLE) && start;
        shift = (state_q == ST_SHIFT) && phase_q && !last_hi;
        clear = last_hi;
    end

    AST_BUSY_IGNORES_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q != ST_IDLE) |=> (state_q != ST_SETUP)); // R10
    AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (low_q == LOW_LEN)); // R8
    AST_SETUP_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state_q == ST_IDLE) |=> (state_q == ST_SETUP)); // R3
endmodule

// File: rtl/par_dac_writer.sv
module par_dac_writer #(
    parameter int NUM_CH    = 8,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 12,
    parameter int REG_W     = 32,
    parameter int TRIG_OFS  = 'h100,
    parameter int CH_BASE   = 'h104,
    parameter int CH_STRIDE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              dac_sclk,
    output logic              dac_cs_n,
    output logic [NUM_CH-1:0] dac_sdo
);
    logic [NUM_CH*DATA_W-1:0] ch_flat;
    logic start, busy, load, shift, clear;

    pdw_regbank #(
        .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_W(REG_W),
        .TRIG_OFS(TRIG_OFS), .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .busy(busy), .rdata(reg_rdata), .ch_flat(ch_flat), .start(start)
    );

    pdw_seq #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .load(load),
        .shift(shift), .clear(clear), .sclk(dac_sclk), .cs_n(dac_cs_n)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        pdw_lane #(.DATA_W(DATA_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .load(load), .shift(shift), .clear(clear),
            .din(ch_flat[g*DATA_W +: DATA_W]), .sdo(dac_sdo[g])
        );
    end

    AST_IDLE_LANES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        dac_cs_n |-> (dac_sdo == '0)); // R1
    AST_SCLK_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sclk |-> !dac_cs_n); // R6
    AST_SCLK_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sclk) |=> $fell(dac_sclk)); // R6
    AST_LANE_CHANGES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n && $past(!dac_cs_n) && !$stable(dac_sdo)) |-> $fell(dac_sclk)); // R7
endmodule

// File: tb/par_dac_writer_tb.sv
module par_dac_writer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    localparam logic [11:0] TRIG_A = 12'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dac_sclk, dac_cs_n;
    logic [7:0]  dac_sdo;

    int checks = 0;
    int errors = 0;
    int frames_seen = 0;
    int frames_exp = 0;
    bit done = 0;

    logic [127:0] exp_q[$];
    logic [15:0]  shadow [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    par_dac_writer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dac_sclk(dac_sclk),
        .dac_cs_n(dac_cs_n), .dac_sdo(dac_sdo)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        for (int i = 0; i < NCH; i++)
            if (a == 12'(12'h104 + 4*i)) shadow[i] = d[15:0];
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    // driver: a 0-to-1 trigger while idle pushes the snapshot of the channels
    task automatic fire();
        logic [127:0] snap;
        wr_reg(TRIG_A, 32'h0);
        for (int i = 0; i < NCH; i++) snap[i*16 +: 16] = shadow[i];
        exp_q.push_back(snap);
        frames_exp++;
        wr_reg(TRIG_A, 32'h1);
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // monitor
    logic       prev_cs = 1'b1, prev_sclk = 1'b0, in_frame = 1'b0;
    logic [7:0] prev_sdo = '0;
    logic [15:0] cap [NCH];
    int low_cyc, nbits, last_rise;
    bit gap_ok, stab_ok;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_cs = 1'b1; prev_sclk = 1'b0; in_frame = 1'b0; prev_sdo = '0;
        end else begin
            if (!dac_cs_n && prev_cs) begin
                in_frame = 1'b1; low_cyc = 1; nbits = 0; last_rise = 0;
                gap_ok = 1; stab_ok = 1;
                for (int i = 0; i < NCH; i++) cap[i] = '0;
                if (exp_q.size() == 0) chk(1'b0, "R8 spurious chip-select", 32'h1, 32'h0);
            end else if (!dac_cs_n) begin
                low_cyc++;
            end
            if (dac_sclk && dac_cs_n) chk(1'b0, "R6 clock outside frame", 32'h1, 32'h0);
            if (!dac_cs_n && dac_sclk && !prev_sclk) begin
                if (nbits > 0 && (low_cyc - last_rise) != 2) gap_ok = 0;
                if (dac_sdo != prev_sdo) stab_ok = 0;
                last_rise = low_cyc;
                for (int i = 0; i < NCH; i++) cap[i] = {cap[i][14:0], dac_sdo[i]};
                nbits++;
            end
            if (dac_cs_n && !prev_cs && in_frame) begin
                logic [127:0] e;
                in_frame = 1'b0;
                frames_seen++;
                chk(low_cyc == 33, "R8 chip-select low length", 32'(low_cyc), 32'd33);
                chk(nbits == 16, "R5 bits per frame", 32'(nbits), 32'd16);
                chk(gap_ok, "R6 rising-edge spacing", 32'(gap_ok), 32'd1);
                chk(stab_ok, "R7 lane stable at rising edge", 32'(stab_ok), 32'd1);
                if (exp_q.size() != 0) begin
                    e = exp_q.pop_front();
                    for (int i = 0; i < NCH; i++)
                        chk(cap[i] == e[i*16 +: 16], "R5 R9 lane word", 32'(cap[i]), 32'(e[i*16 +: 16]));
                end
            end
            prev_cs = dac_cs_n; prev_sclk = dac_sclk; prev_sdo = dac_sdo;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R5 watchdog expired", 32'd50000, 32'd0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] vals [NCH];
        for (int i = 0; i < NCH; i++) shadow[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(dac_cs_n == 1'b1, "R1 cs_n idle", 32'(dac_cs_n), 32'd1);
        chk(dac_sclk == 1'b0, "R1 sclk idle", 32'(dac_sclk), 32'd0);
        chk(dac_sdo == 8'h0, "R1 lanes idle", 32'(dac_sdo), 32'd0);
        rd_chk(TRIG_A, 32'h0, "R1 trigger reset");
        for (int i = 0; i < NCH; i++) rd_chk(12'(12'h104 + 4*i), 32'h0, "R1 channel reset");

        // R2 write and read back with sign extension
        vals = '{16'h8001, 16'h7FFE, 16'hA5A5, 16'h5A5A, 16'h0000, 16'hFFFF, 16'h1234, 16'h8000};
        for (int i = 0; i < NCH; i++) wr_reg(12'(12'h104 + 4*i), {16'hDEAD, vals[i]});
        for (int i = 0; i < NCH; i++)
            rd_chk(12'(12'h104 + 4*i), {{16{vals[i][15]}}, vals[i]}, "R2 readback");

        // first frame; R4 busy visible
        fire();
        rd_chk(TRIG_A, 32'h3, "R4 busy during frame");
        wait_drain();
        rd_chk(TRIG_A, 32'h1, "R4 idle after frame");

        // R3 writing 1 again while bit already set starts nothing
        wr_reg(TRIG_A, 32'h1);
        repeat (60) @(negedge clk);
        chk(frames_seen == frames_exp, "R3 no frame without edge", 32'(frames_seen), 32'(frames_exp));
        chk(dac_cs_n == 1'b1, "R3 cs_n stays high", 32'(dac_cs_n), 32'd1);

        // second pattern: walking ones; R9 mid-frame write, R10 retrigger while busy
        for (int i = 0; i < NCH; i++) wr_reg(12'(12'h104 + 4*i), 32'(16'h1 << (2*i)));
        fire();
        repeat (6) @(negedge clk);
        wr_reg(12'h104, 32'h0000C3C3);
        wr_reg(TRIG_A, 32'h0);
        wr_reg(TRIG_A, 32'h1);
        rd_chk(12'h104, 32'hFFFFC3C3, "R2 readback during frame");
        wait_drain();
        repeat (60) @(negedge clk);
        chk(frames_seen == frames_exp, "R10 retrigger ignored", 32'(frames_seen), 32'(frames_exp));

        // R9 next frame picks up the value written mid-frame
        fire();
        wait_drain();

        // third pattern: back-to-back frames with alternating bits
        for (int i = 0; i < NCH; i++) wr_reg(12'(12'h104 + 4*i), (i % 2 == 0) ? 32'h5555 : 32'hAAAA);
        fire();
        wait_drain();
        fire();
        wait_drain();
        chk(frames_seen == frames_exp, "R8 one pulse per trigger", 32'(frames_seen), 32'(frames_exp));
        chk(dac_sdo == 8'h0, "R1 lanes low after frames", 32'(dac_sdo), 32'd0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule